// File: doc/BRIEF.md
# Ingress Traffic Class Classifier

This block watches the first bytes of every frame arriving on a byte-wide receive stream and gives the frame one of eight traffic classes. Management frames go first. A frame counts as management when the top 24 bits of its destination MAC match one of two fixed link-local prefixes. These frames always get the highest class. For any other frame, the block checks whether the EtherType position holds the tag protocol identifier that software has programmed. If it does, the class is the priority field of that tag. If it does not, the class is the port's default priority. Because the identifier is programmable, frames with a standard 0x8100 tag can be handled as untagged.

The block also compares the destination MAC with a set of programmable exact-match filters. On a hit it raises a trap flag, which marks the frame for the CPU port. The class and the trap flag are valid together with a one-cycle done pulse. They then stay unchanged until the next pulse, so a queue manager can latch them whenever it needs them. Frame storage and queueing live elsewhere.

Top module: `tc_classifier`

## Requirements
- R1: After reset, `done` is low and `tclass` and `trap` are 0. `tclass` is a 3-bit class from 0 to 7.
- R2: A frame of at least 15 bytes is tagged when byte 12 (high) and byte 13 (low) equal `tag_tpid`. Its class is then bits 7:5 of byte 14. A 14-byte frame never counts as tagged.
- R3: A frame of at least 14 bytes that is neither tagged nor management gets class `port_pcp`.
- R4: Only the programmed identifier is recognised. If `tag_tpid` is not 0x8100, a frame carrying 0x8100 at bytes 12-13 is handled as untagged.
- R5: A frame of at least 14 bytes whose bytes 0..2 are 01-80-C2 or 01-19-1B gets class 7, even if it carries a tag with another priority.
- R6: In a frame of at least 14 bytes, `trap` is 1 when the 48-bit destination MAC equals any slot of `trap_macs`. Byte 0 is the most significant byte of the MAC, and slot k sits in bits 48k+47:48k.
- R7: `done` pulses for one cycle. It rises in the cycle after the edge that accepts byte 15, or after the edge that accepts a byte with `rx_eof`, whichever comes first.
- R8: A frame shorter than 14 bytes gets class `port_pcp` and `trap` 0, whatever its bytes contain.
- R9: `tclass` and `trap` change only in a cycle where `done` is high. Otherwise they hold their last value.
- R10: Bytes after byte 15 and bytes that arrive outside a frame are ignored. An `rx_sof` in the middle of a frame drops the partial frame without a result and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A byte is present on `rx_data` |
| rx_sof | input | 1 | The present byte is byte 0 of a frame |
| rx_eof | input | 1 | The present byte is the last byte of the frame |
| rx_data | input | 8 | Frame byte |
| port_pcp | input | 3 | Default priority of this port |
| tag_tpid | input | 16 | Identifier that marks a VLAN tag |
| trap_macs | input | N_TRAP*48 | Destination MAC filters for trapping to the CPU |
| tclass | output | 3 | Traffic class |
| trap | output | 1 | Frame is to be trapped to the CPU |
| done | output | 1 | One-cycle pulse: result is valid |

## Verification
Every result is due exactly one cycle after the rising edge that accepts the deciding byte. The deciding byte is byte 15, or the closing byte of a shorter frame. As it drives that byte, the driver pushes the expected class and trap flag onto a queue, together with that due cycle. The monitor samples on the falling edge. Each time `done` is high it pops one entry and checks the values and the cycle. A `done` with an empty queue counts as a failure, which covers trailing bytes and abandoned frames. Separate checks cover reset values and the holding of results between pulses.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    localparam int CNT_W  = 5;
    localparam int MAC_W  = 48;
    localparam int BYTE_W = 8;
    localparam int TC_W   = 3;

    // byte positions that drive decisions
    localparam logic [CNT_W-1:0] DMAC_BYTES = 5'd6;
    localparam logic [CNT_W-1:0] IDX_ETH_HI = 5'd12;
    localparam logic [CNT_W-1:0] IDX_ETH_LO = 5'd13;
    localparam logic [CNT_W-1:0] IDX_PRIO   = 5'd14;
    localparam logic [CNT_W-1:0] IDX_LAST   = 5'd15;
    localparam logic [CNT_W-1:0] MIN_LEN    = 5'd14;
    localparam logic [CNT_W-1:0] PRIO_LEN   = 5'd15;

    localparam logic [23:0]     MGMT_PFX_A = 24'h0180C2;
    localparam logic [23:0]     MGMT_PFX_B = 24'h01191B;
    localparam logic [TC_W-1:0] MGMT_TC    = 3'd7;

    typedef struct packed {
        logic [MAC_W-1:0] dmac;
        logic [15:0]      etype;
        logic [TC_W-1:0]  prio;
        logic [CNT_W-1:0] cnt;
        logic             active;
    } hdr_t;

    typedef struct packed {
        logic [TC_W-1:0] tc;
        logic            trap;
        logic            done;
    } res_t;
endpackage

// File: rtl/tcc_hdr_capture.sv
module tcc_hdr_capture
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [BYTE_W-1:0] in_data,
    output logic [MAC_W-1:0]  nx_dmac,
    output logic [15:0]       nx_etype,
    output logic [TC_W-1:0]   nx_prio,
    output logic [CNT_W-1:0]  nx_cnt,
    output logic              fire
);
    hdr_t hdr_q, hdr_d, base;
    logic accept;

    always_comb begin
        base   = in_sof ? '0 : hdr_q;
        accept = in_valid && (in_sof || hdr_q.active);
        hdr_d  = hdr_q;
        fire   = 1'b0;
        if (accept) begin
            hdr_d     = base;
            hdr_d.cnt = base.cnt + 5'd1;
            if (base.cnt < DMAC_BYTES)
                hdr_d.dmac = {base.dmac[MAC_W-BYTE_W-1:0], in_data};
            if (base.cnt == IDX_ETH_HI || base.cnt == IDX_ETH_LO)
                hdr_d.etype = {base.etype[7:0], in_data};
            if (base.cnt == IDX_PRIO)
                hdr_d.prio = in_data[7:5];
            fire         = in_eof || (base.cnt == IDX_LAST);
            hdr_d.active = !fire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hdr_q <= '0;
        else        hdr_q <= hdr_d;
    end

    assign nx_dmac  = hdr_d.dmac;
    assign nx_etype = hdr_d.etype;
    assign nx_prio  = hdr_d.prio;
    assign nx_cnt   = hdr_d.cnt;
endmodule

// File: rtl/tcc_decide.sv
module tcc_decide
    import tcc_pkg::*;
#(
    parameter int N_TRAP = 2
) (
    input  logic [MAC_W-1:0]        dmac,
    input  logic [15:0]             etype,
    input  logic [TC_W-1:0]         prio,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [TC_W-1:0]         port_pcp,
    input  logic [15:0]             tag_tpid,
    input  logic [N_TRAP*MAC_W-1:0] trap_macs,
    output logic [TC_W-1:0]         tc,
    output logic                    trap
);
    logic [N_TRAP-1:0] hit;
    logic long_enough, has_prio, is_mgmt, is_tagged;

    for (genvar k = 0; k < N_TRAP; k++) begin : g_filt
        assign hit[k] = (dmac == trap_macs[k*MAC_W +: MAC_W]);
    end

    always_comb begin
        long_enough = (cnt >= MIN_LEN);
        has_prio    = (cnt >= PRIO_LEN);
        is_mgmt     = long_enough && (dmac[MAC_W-1 -: 24] == MGMT_PFX_A ||
                                      dmac[MAC_W-1 -: 24] == MGMT_PFX_B);
        is_tagged   = has_prio && (etype == tag_tpid);
        if (is_mgmt)        tc = MGMT_TC;
        else if (is_tagged) tc = prio;
        else                tc = port_pcp;
        trap = long_enough && (|hit);
    end
endmodule

// File: rtl/tc_classifier.sv
module tc_classifier
    import tcc_pkg::*;
#(
    parameter int N_TRAP = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic [2:0]              port_pcp,
    input  logic [15:0]             tag_tpid,
    input  logic [N_TRAP*48-1:0]    trap_macs,
    output logic [2:0]              tclass,
    output logic                    trap,
    output logic                    done
);
    logic [MAC_W-1:0] nx_dmac;
    logic [15:0]      nx_etype;
    logic [TC_W-1:0]  nx_prio, dec_tc;
    logic [CNT_W-1:0] nx_cnt;
    logic             fire, dec_trap;
    res_t             res_q, res_d;

    tcc_hdr_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_sof   (rx_sof),
        .in_eof   (rx_eof),
        .in_data  (rx_data),
        .nx_dmac  (nx_dmac),
        .nx_etype (nx_etype),
        .nx_prio  (nx_prio),
        .nx_cnt   (nx_cnt),
        .fire     (fire)
    );

    tcc_decide #(.N_TRAP(N_TRAP)) u_dec (
        .dmac      (nx_dmac),
        .etype     (nx_etype),
        .prio      (nx_prio),
        .cnt       (nx_cnt),
        .port_pcp  (port_pcp),
        .tag_tpid  (tag_tpid),
        .trap_macs (trap_macs),
        .tc        (dec_tc),
        .trap      (dec_trap)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (fire) begin
            res_d.tc   = dec_tc;
            res_d.trap = dec_trap;
            res_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign tclass = res_q.tc;
    assign trap   = res_q.trap;
    assign done   = res_q.done;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_sof,
    input logic       rx_eof,
    input logic [2:0] port_pcp,
    input logic [2:0] tclass,
    input logic       trap,
    input logic       done
);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(tclass) && $stable(trap)));

    // R7
    one_byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && rx_eof) |=> done);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rx_valid));

    // R8
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(rx_valid && rx_sof && rx_eof)) |->
            (tclass == $past(port_pcp) && !trap));

    // R1
    no_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({done, trap, tclass}));
endmodule

bind tc_classifier tcc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_sof   (rx_sof),
    .rx_eof   (rx_eof),
    .port_pcp (port_pcp),
    .tclass   (tclass),
    .trap     (trap),
    .done     (done)
);

// File: tb/sim_tc_classifier.sv
module sim_tc_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [2:0]  port_pcp = 3'd0;
    logic [15:0] tag_tpid = 16'h8100;
    logic [47:0] filt0 = 48'h0180C200000E, filt1 = 48'h021122334455;
    logic [95:0] trap_macs;
    logic [2:0]  tclass;
    logic        trap, done;

    assign trap_macs = {filt1, filt0};

    tc_classifier u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .port_pcp(port_pcp),
        .tag_tpid(tag_tpid), .trap_macs(trap_macs),
        .tclass(tclass), .trap(trap), .done(done)
    );

    always #5 clk = ~clk;

    int    cyc = 0;
    int    checks = 0, bad = 0;
    logic [7:0] fr [0:31];
    int    q_due[$];
    logic [3:0] q_val[$];
    string q_req[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic mk(input logic [47:0] da, input logic [15:0] et, input logic [7:0] tci);
        for (int i = 0; i < 32; i++) fr[i] = 8'(i + 8'h30);
        for (int i = 0; i < 6; i++) fr[i] = da[47 - 8*i -: 8];
        fr[12] = et[15:8];
        fr[13] = et[7:0];
        fr[14] = tci;
    endtask

    function automatic logic [3:0] model(input int len);
        int n;
        logic [47:0] da;
        logic tp;
        n = (len > 16) ? 16 : len;
        if (n < 14) return {port_pcp, 1'b0};
        da = {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]};
        tp = (da == filt0) || (da == filt1);
        if (da[47:24] == 24'h0180C2 || da[47:24] == 24'h01191B) return {3'd7, tp};
        if (n >= 15 && {fr[12], fr[13]} == tag_tpid) return {fr[14][7:5], tp};
        return {port_pcp, tp};
    endfunction

    task automatic send(input int len, input int gap, input bit with_eof, input string req);
        int fin;
        fin = (len < 16) ? len - 1 : 15;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = fr[i];
            rx_sof   = (i == 0);
            rx_eof   = with_eof && (i == len - 1);
            if (i == fin && (with_eof || i == 15)) begin
                q_due.push_back(cyc + 1);
                q_val.push_back(model(len));
                q_req.push_back(req);
            end
            @(negedge clk);
            rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
            if (gap > 0) repeat (gap) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            checks++;
            if (q_due.size() == 0) begin
                bad++;
                $display("FAIL R7/R10 unexpected done: actual tc=%0d trap=%0d expected no result",
                         tclass, trap);
            end else begin
                int due;
                logic [3:0] ev;
                string rq;
                due = q_due.pop_front();
                ev  = q_val.pop_front();
                rq  = q_req.pop_front();
                if ({tclass, trap} !== ev || cyc != due) begin
                    bad++;
                    $display("FAIL %s: actual tc=%0d trap=%0d cyc=%0d expected tc=%0d trap=%0d cyc=%0d",
                             rq, tclass, trap, cyc, ev[3:1], ev[0], due);
                end
            end
        end
    end

    task automatic check_hold(input logic [2:0] etc, input logic etr);
        checks++;
        if (tclass !== etc || trap !== etr || done !== 1'b0) begin
            bad++;
            $display("FAIL R9 hold: actual tc=%0d trap=%0d done=%0d expected tc=%0d trap=%0d done=0",
                     tclass, trap, done, etc, etr);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (done !== 1'b0 || tclass !== 3'd0 || trap !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: actual tc=%0d trap=%0d done=%0d expected 0 0 0", tclass, trap, done);
        end
        rst_n = 1'b1;
        @(negedge clk);
        port_pcp = 3'd2;

        // R2 tagged with standard identifier, trailing bytes ignored (R10)
        mk(48'h00AABBCCDDEE, 16'h8100, 8'hA3); send(20, 0, 1, "R2 tagged pcp5");
        // R3 untagged gets port default
        mk(48'h00AABBCCDDEE, 16'h0800, 8'hE0); send(30, 1, 1, "R3 untagged default");
        // R9 hold after the pulse
        repeat (3) @(negedge clk);
        check_hold(3'd2, 1'b0);
        // R4 custom identifier: 0x8100 frame untagged, custom tag recognised
        tag_tpid = 16'hDADA;
        port_pcp = 3'd4;
        mk(48'h00AABBCCDDEE, 16'h8100, 8'hC0); send(18, 0, 1, "R4 8100 ignored");
        mk(48'h00AABBCCDDEE, 16'hDADA, 8'h20); send(18, 2, 1, "R2 custom tag pcp1");
        tag_tpid = 16'h8100;
        // R5 management overrides tag
        mk(48'h0180C2000001, 16'h8100, 8'h20); send(16, 0, 1, "R5 mgmt 0180C2 tagged");
        mk(48'h01191B000000, 16'h0800, 8'h00); send(16, 0, 1, "R5 mgmt 01191B");
        // R6 trap filters
        mk(48'h0180C200000E, 16'h8100, 8'h40); send(20, 0, 1, "R6 trap slot0 mgmt");
        mk(48'h021122334455, 16'h8100, 8'h60); send(20, 0, 1, "R6 trap slot1 tagged");
        mk(48'h021122334456, 16'h0800, 8'h60); send(20, 0, 1, "R6 near miss no trap");
        // R8 short frames ignore management and filters
        mk(48'h0180C200000E, 16'h8100, 8'hE0); send(10, 0, 1, "R8 short 10B");
        send(1, 0, 1, "R8 one byte");
        send(13, 1, 1, "R8 13B");
        // R2 boundaries: 14 bytes untagged, 15 bytes tagged
        mk(48'h00AABBCCDDEE, 16'h8100, 8'hE0); send(14, 0, 1, "R2 14B no prio byte");
        send(15, 0, 1, "R2 15B tagged");
        // R7 exact 16-byte frame with eof on byte 15
        send(16, 0, 1, "R7 16B");
        // R10 abandoned frame then restart
        mk(48'h021122334455, 16'h8100, 8'hA0); send(8, 0, 0, "R10 abandoned");
        mk(48'h00AABBCCDDEE, 16'h8100, 8'h00); send(17, 0, 1, "R10 restart");
        // R10 bytes outside a frame are ignored
        rx_valid = 1'b1; rx_data = 8'h01;
        repeat (20) @(negedge clk);
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_hold(3'd0, 1'b0);
        repeat (4) @(negedge clk);
        checks++;
        if (q_due.size() != 0) begin
            bad++;
            $display("FAIL R7 missing done: actual pending=%0d expected 0", q_due.size());
        end
        finish_run();
    end
endmodule